// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Replay and Half-Level Flag

This block is a first-in first-out buffer of 9-bit words. The write and read controls are active-low strobes, and the whole block runs in one clock domain. Each strobe is sampled on the clock, and only its high-to-low transition moves a pointer. A strobe held low for many cycles therefore transfers one word. Empty and full flags stop underrun and overrun. A third status pin works in one of two ways, chosen by a parameter. In standalone builds it reports that the buffer is more than half occupied. In depth-expansion builds it gives a one-cycle token when the buffer has just filled, so that a following buffer can take over.

The depth is a parameter, and it must be a power of two from 256 to 4096 words. The read data leaves through a registered data bus with an output-enable. The enable is deasserted whenever the sampled read strobe is high, and it stands in for a tri-state output. A low level on the replay input rewinds the read side to location zero while both strobes are high. The data already read can then be read a second time.

Top module: `strobe_fifo`

## Requirements
- R1: Words come out of `q` in exactly the order they were accepted. A read accepted at a clock edge places the oldest unread word on `q` after that edge, and `q` keeps its value at every other edge.
- R2: A write or a read happens only at an edge where the strobe is sampled low and was sampled high at the edge before. A strobe held low for several cycles moves its pointer by one word.
- R3: `empty` is 1 exactly when the occupancy is zero. A read strobe while empty leaves `q` and the occupancy unchanged.
- R4: `full` is 1 exactly when the occupancy equals DEPTH. A write strobe while full is dropped: the stored data and the occupancy stay unchanged.
- R5: In standalone mode (EXPAND=0), `level_flag` is 1 exactly when the occupancy is at least DEPTH/2+1.
- R6: `q_oe` is 1 in the cycle after an edge where `rd_n` was sampled low, and 0 after an edge where `rd_n` was sampled high.
- R7: At an edge where `rt_n` is low and both `wr_n` and `rd_n` are high, the read location returns to zero and the occupancy becomes the current write location. The write location is unchanged, and the flags follow the new occupancy.
- R8: While `rst_n` is low, both locations and the occupancy are cleared and `q` is set to 0. `empty` is then 1, and `full`, `level_flag` and `q_oe` are 0.
- R9: In expansion mode (EXPAND=1), `level_flag` is a one-cycle pulse after an accepted write that brings the occupancy to DEPTH. It is 0 in every other cycle.
- R10: When both strobes fall at the same edge, the blocking flags are taken from the occupancy before that edge. When empty, the write is accepted and the read is dropped. When full, the read is accepted and the write is dropped. Otherwise both are accepted and the occupancy stays the same.

Parameters: `DEPTH` sets the number of words and `EXPAND` selects the mode of `level_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which all strobes are sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low replay request |
| d | input | 9 | Write data |
| q | output | 9 | Registered read data |
| q_oe | output | 1 | Output-enable for `q`; 0 means high-impedance |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| level_flag | output | 1 | Half-full flag (EXPAND=0) or expansion token (EXPAND=1) |

## Verification
Two functions can fall in one cycle: a write strobe edge and a read strobe edge arriving at the same clock edge. The bench provokes this in three states: an empty buffer, a full buffer, and a buffer partly filled. Both strobes are dropped on the same negative edge, so they are sampled together. A behavioural queue model decides which side is accepted from the occupancy before that edge. It then predicts `q`, the flags and the expansion token, and these predictions are compared with both instances after every edge.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
   localparam int WORD_W = 9;
   localparam int MIN_DEPTH = 256;
   localparam int MAX_DEPTH = 4096;

   typedef logic [WORD_W-1:0] word_t;

   function automatic bit depth_ok(input int dep);
      return (dep >= MIN_DEPTH) && (dep <= MAX_DEPTH) && ((dep & (dep - 1)) == 0);
   endfunction
endpackage

// File: rtl/fifo_strobe_edge.sv
module fifo_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall,
   output logic held_low
);
   logic last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= strobe_n;
   end

   assign fall     = last_q & ~strobe_n;
   assign held_low = ~last_q;

   // R2: two transitions can never be detected in consecutive cycles
   p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/fifo_store.sv
module fifo_store
   import fifo_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  word_t         wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output word_t         rdata
);
   word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

   // R10: an accepted read and an accepted write never share a location
   p_no_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && re) |-> (waddr != raddr));
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
   parameter int DEPTH  = 512,
   parameter bit EXPAND = 1'b0,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_fall,
   input  logic          rd_fall,
   input  logic          rt_req,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic          empty,
   output logic          full,
   output logic          level_flag
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2 + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

   logic [CW-1:0] occ;
   logic          token_q;

   assign empty = (occ == '0);
   assign full  = (occ == FULL_CNT);
   assign wr_ok = wr_fall & ~full;
   assign rd_ok = rd_fall & ~empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr <= '0;
         rd_addr <= '0;
         occ     <= '0;
         token_q <= 1'b0;
      end else begin
         token_q <= 1'b0;
         if (rt_req) begin
            rd_addr <= '0;
            occ     <= CW'(wr_addr);
         end else begin
            if (wr_ok) wr_addr <= wr_addr + 1'b1;
            if (rd_ok) rd_addr <= rd_addr + 1'b1;
            occ     <= occ + CW'(wr_ok) - CW'(rd_ok);
            token_q <= wr_ok & ~rd_ok & (occ == LAST_CNT);
         end
      end
   end

   generate
      if (EXPAND) begin : g_token
         assign level_flag = token_q;
      end else begin : g_half
         assign level_flag = (occ >= HALF_CNT);
      end
   endgenerate

   // R4: a dropped write leaves the write location where it was
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_fall) |=> $stable(wr_addr));
   // R3: a dropped read leaves the read location where it was
   p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_fall) |=> $stable(rd_addr));
   // R7: replay rewinds the read side and leaves the write side alone
   p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rt_req |=> (rd_addr == '0) && $stable(wr_addr));
   // R2: the write location only moves after a detected strobe transition
   p_step_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_addr) |-> $past(wr_fall));
   // R3: the two blocking flags are never raised together
   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
   import fifo_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter bit EXPAND = 1'b0,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              rt_n,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q,
   output logic              q_oe,
   output logic              empty,
   output logic              full,
   output logic              level_flag
);
   generate
      if (!depth_ok(DEPTH)) begin : g_bad_depth
         $error("strobe_fifo: DEPTH must be a power of two from 256 to 4096");
      end
   endgenerate

   logic          wr_fall, rd_fall, wr_held, rd_held, rt_req;
   logic          wr_ok, rd_ok;
   logic [AW-1:0] wr_addr, rd_addr;

   fifo_strobe_edge u_wr_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
      .fall(wr_fall), .held_low(wr_held)
   );

   fifo_strobe_edge u_rd_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_n),
      .fall(rd_fall), .held_low(rd_held)
   );

   assign rt_req = ~rt_n & wr_n & rd_n;
   assign q_oe   = rd_held;

   fifo_ctrl #(.DEPTH(DEPTH), .EXPAND(EXPAND)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_fall(wr_fall), .rd_fall(rd_fall), .rt_req(rt_req),
      .wr_addr(wr_addr), .rd_addr(rd_addr),
      .wr_ok(wr_ok), .rd_ok(rd_ok),
      .empty(empty), .full(full), .level_flag(level_flag)
   );

   fifo_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_ok), .waddr(wr_addr), .wdata(d),
      .re(rd_ok), .raddr(rd_addr), .rdata(q)
   );

   // R6: the output is enabled only after the read strobe was seen low
   p_oe_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q_oe == !$past(rd_n)));
   // R1: the data bus holds its value when no read is accepted
   p_hold_q_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok |=> $stable(q));
   // R2: a strobe held low is not seen again
   p_held_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_held |-> !wr_fall);
endmodule

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
   localparam int D = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
   logic [8:0] d = '0;
   logic [8:0] q, q_x;
   logic q_oe, empty, full, level_flag;
   logic q_oe_x, empty_x, full_x, token_x;

   int n_run = 0, n_fail = 0, cyc = 0;
   string phase = "R8";

   always #5 clk = ~clk;

   strobe_fifo #(.DEPTH(D), .EXPAND(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .d(d),
      .q(q), .q_oe(q_oe), .empty(empty), .full(full), .level_flag(level_flag)
   );

   strobe_fifo #(.DEPTH(D), .EXPAND(1'b1)) dut_x (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .d(d),
      .q(q_x), .q_oe(q_oe_x), .empty(empty_x), .full(full_x), .level_flag(token_x)
   );

   // behavioural model
   logic [8:0] m_mem [D];
   int  m_wa = 0, m_ra = 0, m_cnt = 0;
   logic [8:0] m_q = '0;
   bit  m_oe = 0, m_tok = 0, m_pw = 1, m_pr = 1;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_wa = 0; m_ra = 0; m_cnt = 0; m_q = '0;
         m_oe = 0; m_tok = 0; m_pw = 1; m_pr = 1;
      end else begin
         bit wok, rok, rt;
         wok = m_pw && !wr_n && (m_cnt < D);
         rok = m_pr && !rd_n && (m_cnt > 0);
         rt  = !rt_n && wr_n && rd_n;
         m_tok = 0;
         if (rt) begin
            m_ra = 0;
            m_cnt = m_wa;
         end else begin
            if (rok) begin
               m_q = m_mem[m_ra];
               m_ra = (m_ra + 1) % D;
            end
            if (wok) begin
               m_mem[m_wa] = d;
               m_wa = (m_wa + 1) % D;
            end
            m_cnt = m_cnt + int'(wok) - int'(rok);
            m_tok = wok && !rok && (m_cnt == D);
         end
         m_oe = !rd_n;
         m_pw = wr_n;
         m_pr = rd_n;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h (phase %s, cycle %0d)",
                  req, what, act, exp, phase, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (cyc > 0) begin
         chk("R1", "q", q, m_q);
         chk("R1", "q_x", q_x, m_q);
         chk("R6", "q_oe", q_oe, m_oe);
         chk("R3", "empty", empty, m_cnt == 0);
         chk("R4", "full", full, m_cnt == D);
         chk("R5", "half", level_flag, m_cnt >= D/2 + 1);
         chk("R9", "token", token_x, m_tok);
         chk("R4", "full_x", full_x, m_cnt == D);
         if (!rst_n) chk("R8", "reset_empty", empty, 1);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(logic [8:0] v, int hold = 1);
      d = v; wr_n = 1'b0; tick(hold);
      wr_n = 1'b1; tick();
   endtask

   task automatic rd(int hold = 1);
      rd_n = 1'b0; tick(hold);
      rd_n = 1'b1; tick();
   endtask

   task automatic both(logic [8:0] v);
      d = v; wr_n = 1'b0; rd_n = 1'b0; tick();
      wr_n = 1'b1; rd_n = 1'b1; tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(2);
      rst_n = 1'b1; tick();
   endtask

   initial begin
      // R8: reset state
      phase = "R8";
      tick(3);
      rst_n = 1'b1; tick();

      // R2: held strobes move one word each
      phase = "R2";
      for (int i = 0; i < 5; i++) wr(9'(i * 37 + 3), i + 1);
      for (int i = 0; i < 5; i++) rd(4 - i + 1);

      // R3: reads on an empty buffer
      phase = "R3";
      rd(); rd(3);

      // R4, R5: fill past half and to full, then push more
      phase = "R4";
      for (int i = 0; i < D; i++) wr(9'(i ^ 9'h15A));
      wr(9'h1FF); wr(9'h0AA);

      // R10: simultaneous strobes at full, mid-level and empty
      phase = "R10";
      both(9'h123);
      for (int i = 0; i < 100; i++) rd();
      both(9'h055); both(9'h1C3);
      for (int i = 0; i < D; i++) rd();
      both(9'h077);
      rd();

      // R7: replay after partial read
      phase = "R7";
      do_reset();
      for (int i = 0; i < 10; i++) wr(9'(i + 9'h100));
      for (int i = 0; i < 6; i++) rd();
      rt_n = 1'b0; tick(2);
      rt_n = 1'b1; tick();
      for (int i = 0; i < 11; i++) rd();
      // replay request ignored while a strobe is low
      wr(9'h033);
      rd_n = 1'b0; rt_n = 1'b0; tick();
      rd_n = 1'b1; rt_n = 1'b1; tick();
      rd();

      // R9: token on a second fill with a reset in between
      phase = "R9";
      do_reset();
      for (int i = 0; i < D; i++) wr(9'(i));
      rd(); wr(9'h111); tick(2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (cyc >= 200000);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d (phase %s)", cyc, phase);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule